// File: doc/BRIEF.md
# Triggered Conversion Sequencer

This block decides when an analog-to-digital conversion begins and how long it lasts. It serves eight trigger slots. Each slot holds a channel code and an interrupt enable, a result word and a completion flag. When a slot is started, the block divides its clock down to the converter clock. It counts a sample phase whose length comes from one of two four-entry tables, then waits a fixed conversion latency. On the last converter clock it captures the converter's data word into the slot's result, sets the slot's flag and, if enabled, raises the interrupt.

Triggers come from eight hardware pulse inputs, or from software: when software triggering is selected, writing slot 0's word with a live channel code starts slot 0. A trigger that arrives while a conversion runs stays pending. Pending slots are served lowest number first. In continuous mode a finished slot re-arms itself. The converter itself is a stub behind a plain port: the block presents the channel of the running slot and samples the data input on the final converter clock. All ports are plain control and status pins with no back-pressure: a register write takes effect at the clock edge it is presented on, and a read returns data in the same cycle.

Top module: `trig_conv_seq`

## Requirements
- R1: After reset every slot word reads 0x1F (channel code 31 in bits [4:0], interrupt enable at bit 7 clear), the configuration word at address 16 reads 0x200, the status word at address 18 reads 0, and busy and irq are low.
- R2: A slot whose channel code is 31 ignores its hardware trigger: no conversion starts and no flag is set.
- R3: A conversion lasts D*(S+RES_BITS+2) clock cycles from the first cycle busy is high to the cycle the flag is visible, where S is 2, 4, 6 or 8 for a sample select (configuration bits [9:8]) of 0..3 with long-sample (bit 4) clear, and 12, 16, 20 or 24 with it set.
- R4: D is 1, 2, 4 or 8 for a divide field (configuration bits [6:5]) of 0..3.
- R5: With trigger-select (configuration bit 13) at 0, hardware triggers are ignored, and a write to slot 0 (address 0) with a channel code other than 31 starts slot 0. With it at 1, writes start nothing and hardware triggers start their slots.
- R6: busy is high for the whole conversion and low when nothing is running or pending.
- R7: On completion the slot's result (address 8+slot, bits [11:0]) holds the converter data sampled while the block presents that slot's channel on conv_chan, and the slot's flag (status bit slot) is set.
- R8: irq is high while any slot has its flag set and its interrupt enable (bit 7 of the slot word) set. A flag on a slot whose enable is clear leaves irq low.
- R9: A read of a slot's result address clears that slot's flag.
- R10: Triggers that arrive while busy are held pending, and pending slots start in ascending slot order, each after one idle cycle.
- R11: With continuous mode (address 17, bit 6) set, a finished slot starts again by itself. Once the mode is cleared, the running conversion finishes and no further conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; clears a slot flag on a result address |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| hw_trig | input | 8 | One-cycle hardware trigger pulses, one per slot |
| conv_chan | output | 5 | Channel of the running slot for the converter stub |
| conv_data | input | 12 | Converter data word |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The assertions assume that the divide, sample and long-sample fields do not change while a conversion runs, because the tick spacing and the phase bound are checked against the live configuration. The bench writes the configuration only while busy is low and the pending set is empty. The assertions also assume that hardware triggers are single-cycle pulses. The bench drives each trigger high for exactly one cycle and changes inputs only on falling edges.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} tcs_state_t;

  // register map; result addresses follow the slot index
  localparam int A_RES  = 8;
  localparam int A_CFG  = 16;
  localparam int A_MODE = 17;
  localparam int A_STAT = 18;

  // field positions in the configuration word
  localparam int CF_LONG  = 4;
  localparam int CF_DIV   = 5;
  localparam int CF_SSEL  = 8;
  localparam int CF_HWTRG = 13;
  localparam int MD_CONT  = 6;
  localparam int SL_IEN   = 7;
  localparam int ST_BUSY  = 15;

  // sample phase length in converter clocks
  function automatic logic [4:0] samp_len(input logic long_s, input logic [1:0] sel);
    samp_len = long_s ? (5'd12 + {1'b0, sel, 2'b00}) : (5'd2 + {2'b00, sel, 1'b0});
  endfunction
endpackage

// File: rtl/tcs_clkdiv.sv
module tcs_clkdiv #(
  parameter int DIV_W = 2,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign tick = !clear && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + CNT_W'(1);
  end

  // R4: a divided clock never ticks on two adjacent cycles
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> !tick);
endmodule

// File: rtl/tcs_prio.sv
module tcs_prio #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_conv_seq.sv
module trig_conv_seq #(
  parameter int NSLOT    = 8,
  parameter int CH_W     = 5,
  parameter int DW       = 12,
  parameter int RES_BITS = 12,
  parameter int AW       = 5,
  parameter int RW       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [RW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [RW-1:0]    rd_data,
  input  logic [NSLOT-1:0] hw_trig,
  output logic [CH_W-1:0]  conv_chan,
  input  logic [DW-1:0]    conv_data,
  output logic             busy,
  output logic             irq
);
  import tcs_pkg::*;

  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int LAT  = RES_BITS + 2;
  localparam int PH_W = $clog2(24 + LAT + 1);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  tcs_state_t        state;
  logic [CH_W-1:0]   chan_q [NSLOT];
  logic [NSLOT-1:0]  ien_q;
  logic [DW-1:0]     res_q  [NSLOT];
  logic [NSLOT-1:0]  flags, pending;
  logic [RW-1:0]     cfg_q;
  logic              cont_q;
  logic [IW-1:0]     cur_idx;
  logic [CH_W-1:0]   cur_chan;
  logic [PH_W-1:0]   phase, total;
  logic [NSLOT-1:0]  set_v, clr_v, wr_slot, rd_clr, gnt;
  logic [IW-1:0]     gnt_idx;
  logic              any_pend, start, tick, cap, hw_mode;

  assign hw_mode = cfg_q[CF_HWTRG];
  assign total   = PH_W'(samp_len(cfg_q[CF_LONG], cfg_q[CF_SSEL+:2])) + PH_W'(LAT);
  assign start   = (state == ST_IDLE) && any_pend;
  assign cap     = (state == ST_RUN) && tick && (phase == total - PH_W'(1));
  assign busy    = (state == ST_RUN);
  assign conv_chan = cur_chan;
  assign irq     = |(flags & ien_q);

  tcs_clkdiv #(.DIV_W(2)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
    .div_sel(cfg_q[CF_DIV+:2]), .tick(tick));

  tcs_prio #(.N(NSLOT)) u_prio (
    .req(pending), .gnt(gnt), .gnt_idx(gnt_idx), .any(any_pend));

  // per-slot decode of writes, reads and trigger arming
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign wr_slot[i] = wr_en && (wr_addr == AW'(i));
    assign rd_clr[i]  = rd_en && (rd_addr == AW'(A_RES + i));
    if (i == 0) begin : g_sw
      assign set_v[i] = (hw_trig[i] && hw_mode && chan_q[i] != CH_OFF)
                     || (wr_slot[i] && !hw_mode && wr_data[CH_W-1:0] != CH_OFF)
                     || (cap && cont_q && cur_idx == IW'(i));
    end else begin : g_hw
      assign set_v[i] = (hw_trig[i] && hw_mode && chan_q[i] != CH_OFF)
                     || (cap && cont_q && cur_idx == IW'(i));
    end
  end
  assign clr_v = start ? gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RW'(16'h0200);
      cont_q <= 1'b0;
      ien_q  <= '0;
      for (int i = 0; i < NSLOT; i++) chan_q[i] <= CH_OFF;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CFG))  cfg_q  <= wr_data;
      if (wr_addr == AW'(A_MODE)) cont_q <= wr_data[MD_CONT];
      for (int i = 0; i < NSLOT; i++) begin
        if (wr_slot[i]) begin
          chan_q[i] <= wr_data[CH_W-1:0];
          ien_q[i]  <= wr_data[SL_IEN];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_idx  <= '0;
      cur_chan <= CH_OFF;
      phase    <= '0;
      pending  <= '0;
    end else begin
      pending <= (pending & ~clr_v) | set_v;
      if (start) begin
        state    <= ST_RUN;
        cur_idx  <= gnt_idx;
        cur_chan <= chan_q[gnt_idx];
        phase    <= '0;
      end else if (state == ST_RUN && tick) begin
        if (cap) state <= ST_IDLE;
        else     phase <= phase + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      for (int i = 0; i < NSLOT; i++) res_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (cap && cur_idx == IW'(i)) begin
          res_q[i] <= conv_data;
          flags[i] <= 1'b1;
        end else if (rd_clr[i]) begin
          flags[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_data[CH_W-1:0] = chan_q[i];
        rd_data[SL_IEN]   = ien_q[i];
      end
      if (rd_addr == AW'(A_RES + i)) rd_data[DW-1:0] = res_q[i];
    end
    if (rd_addr == AW'(A_CFG))  rd_data = cfg_q;
    if (rd_addr == AW'(A_MODE)) rd_data[MD_CONT] = cont_q;
    if (rd_addr == AW'(A_STAT)) begin
      rd_data[NSLOT-1:0] = flags;
      rd_data[ST_BUSY]   = busy;
    end
  end

  // R10: the slot started is pending and no lower slot is waiting
  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (pending[gnt_idx] && ((pending & ((NSLOT'(1) << gnt_idx) - NSLOT'(1))) == '0)));
  // R7: a flag only rises at the edge that captured a result
  a_r7_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) != '0) |-> $past(cap));
  // R6: a running conversion never passes its total length
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase < total));
  // R9: a result read without a same-cycle capture leaves the flag clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr != '0 && !cap) |=> ((flags & $past(rd_clr)) == '0));
endmodule

// File: tb/trig_conv_seq_tb.sv
module trig_conv_seq_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] AD_CFG = 5'd16, AD_MODE = 5'd17, AD_STAT = 5'd18;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [7:0]  hw_trig = '0;
  logic [4:0]  conv_chan;
  logic [11:0] conv_data;
  logic        busy, irq;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;
  assign conv_data = 12'h5A0 + {7'd0, conv_chan};

  trig_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .hw_trig(hw_trig),
    .conv_chan(conv_chan), .conv_data(conv_data), .busy(busy), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a; #1; v = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); hw_trig = m;
    @(negedge clk); hw_trig = '0;
  endtask

  task automatic wait_busy(input logic lvl);
    for (int k = 0; k < 3000 && busy !== lvl; k++) @(negedge clk);
  endtask

  task automatic quiet(input string tag, input int n);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (busy) seen = 1'b1; end
    chk(tag, seen, 1'b0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 busy", busy, 1'b0);
    chk("R1 irq", irq, 1'b0);
    for (int s = 0; s < 8; s++) begin rd(5'(s), v); chk("R1 slot word", v, 16'h001F); end
    rd(AD_CFG, v);  chk("R1 config", v, 16'h0200);
    rd(AD_STAT, v); chk("R1 status", v, 16'h0000);
  endtask

  // hardware trigger on a slot, count cycles from busy to irq
  task automatic t_latency(input string tag, input logic [15:0] cfg, input int s,
                           input logic [4:0] ch, input int exp_cyc);
    logic [15:0] v;
    int cnt;
    logic held;
    wr(AD_CFG, cfg);
    wr(5'(s), 16'h0080 | {11'd0, ch});
    pulse(8'(1 << s));
    wait_busy(1'b1);
    cnt = 0; held = 1'b1;
    while (!irq && cnt < 5000) begin
      if (!busy) held = 1'b0;
      @(negedge clk); cnt++;
    end
    chk({"R3 R4 cycles ", tag}, cnt, exp_cyc);
    chk({"R6 busy held ", tag}, held, 1'b1);
    chk({"R6 busy low after ", tag}, busy, 1'b0);
    rd(5'(8 + s), v);
    chk({"R7 result ", tag}, v, 16'h05A0 + {11'd0, ch});
    rd(AD_STAT, v);
    chk({"R9 flag cleared ", tag}, v, 16'h0000);
    chk({"R8 irq dropped ", tag}, irq, 1'b0);
  endtask

  task automatic t_disabled();
    logic [15:0] v;
    wr(AD_CFG, 16'h2200);
    wr(5'd6, 16'h001F);
    pulse(8'h40);
    quiet("R2 code 31 no start", 30);
    rd(AD_STAT, v); chk("R2 no flag", v, 16'h0000);
    wr(5'd0, 16'h0084);
    quiet("R5 write in hw mode no start", 30);
  endtask

  task automatic t_irq_mask();
    logic [15:0] v;
    wr(AD_CFG, 16'h2200);
    wr(5'd1, 16'h0009);
    pulse(8'h02);
    wait_busy(1'b1); wait_busy(1'b0);
    @(negedge clk);
    chk("R8 masked irq low", irq, 1'b0);
    rd(AD_STAT, v); chk("R8 flag set while masked", v, 16'h0002);
    rd(5'd9, v);    chk("R7 masked result", v, 16'h05A9);
    rd(AD_STAT, v); chk("R9 masked flag cleared", v, 16'h0000);
  endtask

  task automatic t_order();
    logic [15:0] v;
    logic [4:0] got [4];
    logic prev;
    int n;
    wr(AD_CFG, 16'h2200);
    wr(5'd1, 16'h000B);
    wr(5'd2, 16'h000C);
    wr(5'd5, 16'h000F);
    wr(5'd7, 16'h0011);
    pulse(8'hA4);
    wait_busy(1'b1);
    got[0] = conv_chan; n = 1; prev = 1'b1;
    pulse(8'h02);
    for (int k = 0; k < 400 && n < 4; k++) begin
      @(negedge clk);
      if (busy && !prev) begin got[n] = conv_chan; n++; end
      prev = busy;
    end
    chk("R10 first", got[0], 5'd12);
    chk("R10 late lower slot next", got[1], 5'd11);
    chk("R10 third", got[2], 5'd15);
    chk("R10 fourth", got[3], 5'd17);
    wait_busy(1'b0);
    @(negedge clk);
    rd(AD_STAT, v); chk("R10 all flags", v, 16'h00A6);
    for (int s = 0; s < 8; s++) if (v[s]) rd(5'(8 + s), v);
  endtask

  task automatic t_software();
    logic [15:0] v;
    wr(AD_CFG, 16'h0200);
    pulse(8'h01);
    quiet("R5 hw ignored in sw mode", 30);
    wr(5'd0, 16'h0086);
    wait_busy(1'b1);
    chk("R5 sw start", busy, 1'b1);
    chk("R7 channel presented", conv_chan, 5'd6);
    wait_busy(1'b0);
    @(negedge clk);
    chk("R8 irq on sw completion", irq, 1'b1);
    rd(5'd8, v); chk("R7 sw result", v, 16'h05A6);
  endtask

  task automatic t_cont();
    logic [15:0] v;
    int cnt;
    wr(AD_CFG, 16'h0200);
    wr(AD_MODE, 16'h0040);
    wr(5'd0, 16'h0082);
    for (cnt = 0; cnt < 200 && !irq; cnt++) @(negedge clk);
    chk("R11 first completion", irq, 1'b1);
    rd(5'd8, v);
    for (cnt = 0; cnt < 60 && !irq; cnt++) @(negedge clk);
    chk("R11 restarted by itself", irq, 1'b1);
    wr(AD_MODE, 16'h0000);
    rd(5'd8, v);
    wait_busy(1'b0);
    @(negedge clk);
    rd(5'd8, v);
    quiet("R11 stops after mode cleared", 60);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_latency("div1 short2", 16'h2200, 3, 5'd4, 20);
    t_latency("div2 short0", 16'h2020, 4, 5'd7, 32);
    t_latency("div4 long1",  16'h2150, 2, 5'd3, 120);
    t_latency("div8 long3",  16'h2370, 7, 5'd1, 304);
    t_irq_mask();
    t_order();
    t_software();
    t_cont();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule